// File: doc/BRIEF.md
# Locality Monitor Tag Array

This block predicts whether the cache block that an operation targets is probably held in the host's last-level cache. It holds only partial tags, no data, arranged in the same sets and ways as that cache and aged with the same least-recently-used policy. Dispatch logic asks it where to run each operation. A hit means high locality, and the operation runs on the host side. A miss means low locality, and the operation is sent to memory.

The shadow array is trained through one update port. The owner pulses that port for every last-level cache access and also for every operation it sends to memory. Because of the second kind of update, an operation that keeps hitting the same block soon starts to predict a hit and turns back toward the host. Only a slice of the tag is kept, so two blocks in the same set that agree in that slice give a false hit. That cost is accepted in exchange for less storage.

Top module: `lm_locality_monitor`

## Requirements
- R1: After reset every way is invalid, `lk_done` and `lk_host` are 0, and every lookup reports a miss (`lk_host`=0) until an update installs a matching tag.
- R2: A lookup presented with `lk_valid`=1 in cycle T raises `lk_done` in cycle T+1 with `lk_host` giving that address's prediction (1 = hit, run on host; 0 = miss, run in memory). `lk_done` is 0 in any cycle whose preceding cycle carried no lookup.
- R3: Lookups never change the contents of the array or the replacement order. A way that is only looked up keeps its age and is evicted as if it had not been probed.
- R4: An update to an address whose partial tag is absent from its set installs it, so a later lookup of that address predicts a hit.
- R5: A repeated operation on one block predicts memory the first time and, once its issue has been recorded through the update port, predicts the host.
- R6: Address fields: the low log2(BLOCK_BYTES) bits are the block offset and are ignored. The next log2(SETS) bits select the set. The following PTAG_W bits form the partial tag. Higher bits are ignored, so addresses that differ only there give a false hit.
- R7: An update changes only the set it indexes. The same partial tag looked up in any other set still misses.
- R8: Within a set the ages are a permutation of 0..WAYS-1. An update that misses fills the way of age WAYS-1 (least recent), and no two valid ways of a set hold the same partial tag.
- R9: An update that hits makes that way the most recent (age 0), so it survives the next eviction in its set.
- R10: When a lookup and an update fall in the same cycle, the update is applied first. A lookup of the address being updated in that cycle reports a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Physical byte address to predict |
| lk_done | output | 1 | Prediction valid, one cycle after the request |
| lk_host | output | 1 | 1 = tag hit (run on host), 0 = miss (run in memory) |
| up_valid | input | 1 | Update strobe (cache access or operation issued to memory) |
| up_addr | input | ADDR_W | Physical byte address of the update |

## Verification
The bench builds the monitor with 24-bit addresses, 64-byte blocks, 4 sets, 4 ways and 6-bit partial tags. With four ways, a full set and its eviction order are reached in a handful of updates. That is enough to check true-LRU victim choice, refresh on a hit, and the fact that lookups do not age ways. With six-bit partial tags, an aliasing address is a simple shift away, so the false hit can be tested directly, and with four sets the separation between sets can be checked against every other set.

// File: rtl/lm_pkg.sv
package lm_pkg;

  // Index width that stays legal for a count of one.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lm_addr_split.sv
module lm_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned SET_W  = 6,
  parameter int unsigned PTAG_W = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SET_W-1:0]  set_idx,
  output logic [PTAG_W-1:0] ptag
);

  localparam int unsigned SET_LO  = OFF_W;
  localparam int unsigned TAG_LO  = OFF_W + SET_W;
  localparam logic [ADDR_W-1:0] USED_MASK =
    ((ADDR_W'(1) << (TAG_LO + PTAG_W)) - ADDR_W'(1)) & ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  logic unused_addr_bits;

  assign set_idx = addr[SET_LO +: SET_W];
  assign ptag    = addr[TAG_LO +: PTAG_W];

  // Offset bits and tag bits above the partial slice take no part in prediction.
  assign unused_addr_bits = ^(addr & ~USED_MASK);

endmodule

// File: rtl/lm_way_match.sv
module lm_way_match #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned PTAG_W = 10,
  parameter int unsigned IDX_W  = lm_pkg::idx_w(WAYS)
) (
  input  logic [WAYS-1:0][PTAG_W-1:0] tags,
  input  logic [WAYS-1:0]             valid,
  input  logic [PTAG_W-1:0]           probe,
  output logic                        hit,
  output logic [WAYS-1:0]             hit_vec,
  output logic [IDX_W-1:0]            hit_idx
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == probe);
  end

  assign hit = |hit_vec;

  // Encoder of a one-hot vector (uniqueness is held by the fill policy).
  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_idx = hit_idx | IDX_W'(w);
    end
  end

endmodule

// File: rtl/lm_lru_set.sv
module lm_lru_set #(
  parameter int unsigned WAYS  = 16,
  parameter int unsigned IDX_W = lm_pkg::idx_w(WAYS)
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_way,
  output logic [IDX_W-1:0] victim
);

  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(WAYS - 1);

  logic [WAYS-1:0][IDX_W-1:0] ages_q, ages_d;
  logic [WAYS-1:0]            is_oldest;

  // Next-state: touched way becomes youngest, younger ways age by one.
  always_comb begin
    ages_d = ages_q;
    if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (IDX_W'(w) == touch_way) begin
          ages_d[w] = '0;
        end else if (ages_q[w] < ages_q[touch_way]) begin
          ages_d[w] = ages_q[w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      for (int w = 0; w < WAYS; w++) ages_q[w] <= IDX_W'(w);
    end else if (touch) begin
      ages_q <= ages_d;
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < WAYS; w++) begin
      is_oldest[w] = (ages_q[w] == AGE_MAX);
      if (is_oldest[w]) victim = IDX_W'(w);
    end
  end

  AST_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_sn)
    $countones(is_oldest) == 1); // R8

  AST_TOUCH_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_sn)
    touch |=> ages_q[$past(touch_way)] == '0); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    !touch |=> $stable(ages_q)); // R3

endmodule

// File: rtl/lm_locality_monitor.sv
module lm_locality_monitor #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned SETS        = 64,
  parameter int unsigned WAYS        = 16,
  parameter int unsigned PTAG_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_done,
  output logic              lk_host,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr
);

  localparam int unsigned OFF_W = $clog2(BLOCK_BYTES);
  localparam int unsigned SET_W = lm_pkg::idx_w(SETS);
  localparam int unsigned IDX_W = lm_pkg::idx_w(WAYS);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // Shadow tag storage.
  logic [SETS-1:0][WAYS-1:0][PTAG_W-1:0] tag_q, tag_d;
  logic [SETS-1:0][WAYS-1:0]             vld_q, vld_d;

  // Address decode for both ports.
  logic [SET_W-1:0]  up_set, lk_set_in, lk_set_q;
  logic [PTAG_W-1:0] up_ptag, lk_ptag_in, lk_ptag_q;

  lm_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .PTAG_W(PTAG_W))
    u_split_up (.addr(up_addr), .set_idx(up_set), .ptag(up_ptag));

  lm_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .PTAG_W(PTAG_W))
    u_split_lk (.addr(lk_addr), .set_idx(lk_set_in), .ptag(lk_ptag_in));

  // Update path: match in the indexed set, else take that set's oldest way.
  logic                   up_hit;
  logic [WAYS-1:0]        up_hit_vec;
  logic [IDX_W-1:0]       up_hit_idx, up_way;
  logic [SETS-1:0][IDX_W-1:0] victims;

  lm_way_match #(.WAYS(WAYS), .PTAG_W(PTAG_W), .IDX_W(IDX_W)) u_match_up (
    .tags(tag_q[up_set]), .valid(vld_q[up_set]), .probe(up_ptag),
    .hit(up_hit), .hit_vec(up_hit_vec), .hit_idx(up_hit_idx)
  );

  assign up_way = up_hit ? up_hit_idx : victims[up_set];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic set_touch;
    assign set_touch = up_valid && (up_set == SET_W'(s));
    lm_lru_set #(.WAYS(WAYS), .IDX_W(IDX_W)) u_lru (
      .clk(clk), .rst_sn(rst_sn), .touch(set_touch),
      .touch_way(up_way), .victim(victims[s])
    );
  end

  always_comb begin
    tag_d = tag_q;
    vld_d = vld_q;
    if (up_valid) begin
      tag_d[up_set][up_way] = up_ptag;
      vld_d[up_set][up_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)       vld_q <= '0;
    else if (up_valid) vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (up_valid) tag_q <= tag_d;
  end

  // Lookup path: capture request, compare next cycle against the
  // array that already holds any same-cycle update.
  logic lk_pend_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) lk_pend_q <= 1'b0;
    else         lk_pend_q <= lk_valid;
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      lk_set_q  <= lk_set_in;
      lk_ptag_q <= lk_ptag_in;
    end
  end

  logic                lk_hit;
  logic [WAYS-1:0]     lk_vec_unused;
  logic [IDX_W-1:0]    lk_idx_unused;

  lm_way_match #(.WAYS(WAYS), .PTAG_W(PTAG_W), .IDX_W(IDX_W)) u_match_lk (
    .tags(tag_q[lk_set_q]), .valid(vld_q[lk_set_q]), .probe(lk_ptag_q),
    .hit(lk_hit), .hit_vec(lk_vec_unused), .hit_idx(lk_idx_unused)
  );

  assign lk_done = lk_pend_q;
  assign lk_host = lk_pend_q && lk_hit;

  AST_LOOKUP_ANSWERED: assert property (@(posedge clk) disable iff (!rst_sn)
    lk_valid |=> lk_done); // R2

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    !lk_valid |=> !lk_done); // R2

  AST_UPDATE_FIRST: assert property (@(posedge clk) disable iff (!rst_sn)
    (lk_valid && up_valid && lk_set_in == up_set && lk_ptag_in == up_ptag) |=> lk_host); // R10

  AST_UNIQUE_PTAG: assert property (@(posedge clk) disable iff (!rst_sn)
    up_valid |-> $onehot0(up_hit_vec)); // R8

  AST_UPDATE_INSTALLS: assert property (@(posedge clk) disable iff (!rst_sn)
    up_valid |=> vld_q[$past(up_set)][$past(up_way)] && tag_q[$past(up_set)][$past(up_way)] == $past(up_ptag)); // R4

endmodule

// File: tb/tb_lm_locality_monitor.sv
module tb_lm_locality_monitor;

  localparam int unsigned AW    = 24;
  localparam int unsigned BB    = 64;
  localparam int unsigned NSETS = 4;
  localparam int unsigned NWAYS = 4;
  localparam int unsigned PW    = 6;
  localparam int unsigned OFFW  = 6;
  localparam int unsigned SETW  = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_valid, up_valid;
  logic [AW-1:0] lk_addr, up_addr;
  logic          lk_done, lk_host;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lm_locality_monitor #(.ADDR_W(AW), .BLOCK_BYTES(BB), .SETS(NSETS), .WAYS(NWAYS), .PTAG_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_done(lk_done), .lk_host(lk_host), .up_valid(up_valid), .up_addr(up_addr)
  );

  function automatic logic [AW-1:0] mk(input int tag, input int set, input int off);
    return AW'((tag << (SETW + OFFW)) | (set << OFFW) | off);
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic do_update(input logic [AW-1:0] a);
    @(negedge clk);
    up_valid = 1'b1; up_addr = a;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [AW-1:0] a, input logic exp, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, lk_done, 1'b1, "lk_done after request");
    check(req, lk_host, exp, "lk_host prediction");
  endtask

  task automatic t_reset;
    check("R1", lk_done, 1'b0, "lk_done at reset");
    check("R1", lk_host, 1'b0, "lk_host at reset");
    do_lookup(mk(5, 0, 0), 1'b0, "R1");
    do_lookup(mk(9, 3, 12), 1'b0, "R1");
  endtask

  task automatic t_repeat_op;   // R4 R5
    do_lookup(mk(7, 1, 8), 1'b0, "R5");
    do_update(mk(7, 1, 8));
    check("R2", lk_done, 1'b0, "lk_done idle");
    do_lookup(mk(7, 1, 8), 1'b1, "R4");
    do_lookup(mk(7, 1, 8), 1'b1, "R5");
  endtask

  task automatic t_fields;      // R6
    do_lookup(mk(7, 1, 63), 1'b1, "R6");
    do_lookup(mk(7 + 64, 1, 0), 1'b1, "R6");
    do_lookup(mk(7 + 1024, 1, 5), 1'b1, "R6");
    do_lookup(mk(8, 1, 0), 1'b0, "R6");
  endtask

  task automatic t_isolation;   // R7
    for (int s = 0; s < NSETS; s++) begin
      if (s != 1) do_lookup(mk(7, s, 0), 1'b0, "R7");
    end
  endtask

  task automatic t_evict;       // R8
    for (int t = 1; t <= NWAYS; t++) do_update(mk(t, 3, 0));
    for (int t = 1; t <= NWAYS; t++) do_lookup(mk(t, 3, 0), 1'b1, "R8");
    do_update(mk(NWAYS + 1, 3, 0));
    do_lookup(mk(1, 3, 0), 1'b0, "R8");
    for (int t = 2; t <= NWAYS + 1; t++) do_lookup(mk(t, 3, 0), 1'b1, "R8");
  endtask

  task automatic t_refresh;     // R9
    for (int t = 11; t < 11 + NWAYS; t++) do_update(mk(t, 2, 0));
    do_update(mk(11, 2, 0));
    do_update(mk(30, 2, 0));
    do_lookup(mk(11, 2, 0), 1'b1, "R9");
    do_lookup(mk(12, 2, 0), 1'b0, "R9");
    do_lookup(mk(30, 2, 0), 1'b1, "R9");
  endtask

  task automatic t_lookup_no_age;  // R3
    for (int t = 40; t < 40 + NWAYS; t++) do_update(mk(t, 0, 0));
    for (int k = 0; k < 3; k++) do_lookup(mk(40, 0, 0), 1'b1, "R3");
    do_update(mk(50, 0, 0));
    do_lookup(mk(40, 0, 0), 1'b0, "R3");
    do_lookup(mk(41, 0, 0), 1'b1, "R3");
  endtask

  task automatic t_same_cycle;  // R10
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(60, 1, 4);
    up_valid = 1'b1; up_addr = mk(60, 1, 0);
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    check("R10", lk_done, 1'b1, "lk_done same cycle");
    check("R10", lk_host, 1'b1, "update applied before lookup");
    @(negedge clk);
    check("R2", lk_done, 1'b0, "lk_done after idle cycle");
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; up_valid = 1'b0;
    lk_addr = '0; up_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_repeat_op();
    t_fields();
    t_isolation();
    t_evict();
    t_refresh();
    t_lookup_no_age();
    t_same_cycle();
    summary();
  end

endmodule